// File: doc/BRIEF.md
# Standby Power Mode Controller

This controller puts a small microcontroller core into a deep standby state and brings it back out. When the core issues a sleep strobe while the standby-enable control bit is set, the controller turns off the oscillator enable and the common clock enable, and gives a one-cycle reset to a parameterised set of peripheral groups. All other state is kept, because it is never reset. With the standby-enable bit clear, the same strobe only signals the ordinary sleep path and the clocks keep running.

A qualified wake event restarts the oscillator. The controller then holds the clocks off for a settling interval picked by a 3-bit selector, and afterwards re-enables them and pulses an interrupt-start output. The wake event is a falling edge on the active-low NMI line, or a high level on an IRQ line that is enabled, not masked by the CPU and not routed as a transfer trigger. An active-low reset pin gives a second way out, which ends in a reset-exception pulse. An active-low hardware-standby pin overrides everything else. All wake and pin inputs pass through a multi-stage synchroniser clocked by the always-on reference clock. That clock also drives the settling counter.

Top module: `stby_ctrl`

## Requirements
- R1: After reset `osc_en` and `clk_en` are 1. A `sleep_req` strobe with `stby_en`=0 gives a single-cycle `sleep_go` pulse one cycle later, and the clocks stay on. With `stby_en`=1 the same strobe enters standby.
- R2: In software standby `osc_en` and `clk_en` are both 0. `clk_en` is never 1 while `osc_en` is 0.
- R3: On entering software standby every bit of `periph_rst` is 1 for exactly one cycle, in the first standby cycle.
- R4: A wake in software standby sets `osc_en` first. `clk_en` then stays 0 for exactly 2^(BASE_EXP+EXP_STEP*k) cycles, where k is `settle_sel`. After that `clk_en` returns together with a single-cycle `int_start`.
- R5: An IRQ line wakes nothing while its `irq_en` bit is 0, its `irq_masked` bit is 1 or its `irq_to_dma` bit is 1. In each of these cases `osc_en` stays 0.
- R6: `res_n` low in standby sets `osc_en`. `clk_en` returns once the settling count has expired. When `res_n` is high and settling is done, a single-cycle `rst_exc_start` is given and no `int_start`.
- R7: If `res_n` is released before the settling count expires, `clk_en` stays 0 until it expires. Only then is `rst_exc_start` pulsed.
- R8: `hwstby_n` low in any state forces `osc_en`=0 and `clk_en`=0. It takes priority over reset and wake events, including during settling.
- R9: After `hwstby_n` returns high, the controller runs a full settling count and then waits for `res_n` high. It leaves with `rst_exc_start` and never with `int_start`.
- R10: Only a high-to-low NMI transition seen while in standby wakes the block. A line that was already low on entry does not wake it, and NMI edges outside standby have no effect.
- R11: A change on a pin input first affects the outputs after SYNC_STAGES+1 rising clock edges, which is three with the default of two stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the controller |
| sleep_req | input | 1 | One-cycle sleep strobe from the core |
| stby_en | input | 1 | Control bit: 1 sends sleep into software standby |
| settle_sel | input | SEL_W | Settling interval selector k |
| nmi_n | input | 1 | Active-low non-maskable wake line (edge) |
| irq_lvl | input | NUM_IRQ | Active-high IRQ request levels |
| irq_en | input | NUM_IRQ | Per-line IRQ enable |
| irq_masked | input | NUM_IRQ | Per-line CPU-side mask |
| irq_to_dma | input | NUM_IRQ | Per-line routing to transfer trigger instead of interrupt |
| res_n | input | 1 | Active-low reset pin |
| hwstby_n | input | 1 | Active-low hardware standby pin |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | Core and peripheral clock enable |
| periph_rst | output | N_GRP | Reset strobes for the peripheral groups cleared in standby |
| int_start | output | 1 | Pulse: begin interrupt exception handling |
| rst_exc_start | output | 1 | Pulse: begin reset exception handling |
| sleep_go | output | 1 | Pulse: ordinary sleep path selected |

## Verification
On every cycle the assertions check the relations between the outputs. The clock enable never runs without the oscillator. Every pulse output is a single cycle and is only given with clocks on. The interrupt and reset-exception pulses never coincide. A synchronised hardware-standby request shuts everything down on the next cycle. The exact length of the settling interval for each selector value, the rejection of each disqualified IRQ, the ignoring of a held-low NMI, and the different exits through reset and hardware standby can only be shown by the bench's scenarios, compared cycle by cycle against its behavioural model.

// File: rtl/stby_pkg.sv
package stby_pkg;

   typedef enum logic [2:0] {
      ST_RUN      = 3'd0,
      ST_SW_STBY  = 3'd1,
      ST_SETTLE   = 3'd2,
      ST_HW_STBY  = 3'd3,
      ST_RST_HOLD = 3'd4
   } stby_state_e;

endpackage

// File: rtl/stby_sync.sv
// Multi-stage synchroniser for asynchronous pins, one chain per bit.
module stby_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("stby_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/stby_wake.sv
// Wake qualification: NMI edge (or level, by option) and qualified IRQ levels.
module stby_wake #(
   parameter int NUM_IRQ  = 6,
   parameter bit NMI_EDGE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               nmi_s,
   input  logic [NUM_IRQ-1:0] irq_s,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic [NUM_IRQ-1:0] irq_masked,
   input  logic [NUM_IRQ-1:0] irq_to_dma,
   output logic               wake
);

   logic [NUM_IRQ-1:0] irq_ok;
   logic               nmi_hit;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      assign irq_ok[i] = irq_s[i] & irq_en[i] & ~irq_masked[i] & ~irq_to_dma[i];
   end

   if (NMI_EDGE) begin : g_nmi_edge
      logic nmi_prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) nmi_prev <= 1'b1;
         else        nmi_prev <= nmi_s;
      end
      assign nmi_hit = nmi_prev & ~nmi_s;
   end else begin : g_nmi_level
      assign nmi_hit = ~nmi_s;
   end

   assign wake = nmi_hit | (|irq_ok);

endmodule

// File: rtl/stby_timer.sv
// Oscillator settling counter: loads 2^(BASE_EXP+EXP_STEP*sel)-1 on start.
module stby_timer #(
   parameter int SEL_W    = 3,
   parameter int BASE_EXP = 8,
   parameter int EXP_STEP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEL_W-1:0] sel,
   output logic             expire,
   output logic             settled
);

   localparam int MAX_EXP = BASE_EXP + EXP_STEP * ((1 << SEL_W) - 1);
   localparam int CW      = MAX_EXP + 1;

   if (BASE_EXP < 1 || EXP_STEP < 0 || MAX_EXP > 30) begin : g_bad_exp
      $error("stby_timer: settling exponent range out of bounds");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] load;
   logic          busy;

   always_comb begin
      load = (CW'(1) << (BASE_EXP + EXP_STEP * int'(sel))) - CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
      end else if (start) begin
         cnt  <= load;
         busy <= 1'b1;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - CW'(1);
      end
   end

   assign expire  = busy && (cnt == '0);
   assign settled = !busy;

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
   import stby_pkg::*;
#(
   parameter int NUM_IRQ     = 6,
   parameter int SEL_W       = 3,
   parameter int BASE_EXP    = 8,
   parameter int EXP_STEP    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int N_GRP       = 4,
   parameter bit NMI_EDGE    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sleep_req,
   input  logic               stby_en,
   input  logic [SEL_W-1:0]   settle_sel,
   input  logic               nmi_n,
   input  logic [NUM_IRQ-1:0] irq_lvl,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic [NUM_IRQ-1:0] irq_masked,
   input  logic [NUM_IRQ-1:0] irq_to_dma,
   input  logic               res_n,
   input  logic               hwstby_n,
   output logic               osc_en,
   output logic               clk_en,
   output logic [N_GRP-1:0]   periph_rst,
   output logic               int_start,
   output logic               rst_exc_start,
   output logic               sleep_go
);

   if (NUM_IRQ < 1 || NUM_IRQ > 32) begin : g_bad_irq
      $error("stby_ctrl: NUM_IRQ out of range");
   end
   if (N_GRP < 1) begin : g_bad_grp
      $error("stby_ctrl: N_GRP must be at least 1");
   end

   // synchronised pins
   logic [2:0]         pins_s;
   logic [NUM_IRQ-1:0] irq_s;
   logic               nmi_s;
   logic               res_s;
   logic               hw_s;

   stby_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({hwstby_n, res_n, nmi_n}),
      .q     (pins_s)
   );

   stby_sync #(.W(NUM_IRQ), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_lvl),
      .q     (irq_s)
   );

   assign nmi_s = pins_s[0];
   assign res_s = pins_s[1];
   assign hw_s  = pins_s[2];

   logic wake;

   stby_wake #(.NUM_IRQ(NUM_IRQ), .NMI_EDGE(NMI_EDGE)) u_wake (
      .clk        (clk),
      .rst_n      (rst_n),
      .nmi_s      (nmi_s),
      .irq_s      (irq_s),
      .irq_en     (irq_en),
      .irq_masked (irq_masked),
      .irq_to_dma (irq_to_dma),
      .wake       (wake)
   );

   logic tmr_start;
   logic tmr_expire;
   logic tmr_settled;

   stby_timer #(.SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .EXP_STEP(EXP_STEP)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (tmr_start),
      .sel     (settle_sel),
      .expire  (tmr_expire),
      .settled (tmr_settled)
   );

   stby_state_e state, nxt;

   // next-state: hardware standby first, then reset pin, then wake/expiry
   always_comb begin
      nxt       = state;
      tmr_start = 1'b0;
      if (!hw_s) begin
         nxt = ST_HW_STBY;
      end else begin
         unique case (state)
            ST_RUN: begin
               if (!res_s)                    nxt = ST_RST_HOLD;
               else if (sleep_req && stby_en) nxt = ST_SW_STBY;
            end
            ST_SW_STBY: begin
               if (!res_s) begin
                  nxt       = ST_RST_HOLD;
                  tmr_start = 1'b1;
               end else if (wake) begin
                  nxt       = ST_SETTLE;
                  tmr_start = 1'b1;
               end
            end
            ST_SETTLE: begin
               if (!res_s)          nxt = ST_RST_HOLD;
               else if (tmr_expire) nxt = ST_RUN;
            end
            ST_HW_STBY: begin
               nxt       = ST_RST_HOLD;
               tmr_start = 1'b1;
            end
            ST_RST_HOLD: begin
               if (res_s && tmr_settled) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_RUN;
      else        state <= nxt;
   end

   // single-cycle event pulses, registered on the transition
   logic prst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_start     <= 1'b0;
         rst_exc_start <= 1'b0;
         sleep_go      <= 1'b0;
         prst_q        <= 1'b0;
      end else begin
         int_start     <= (state == ST_SETTLE)   && (nxt == ST_RUN);
         rst_exc_start <= (state == ST_RST_HOLD) && (nxt == ST_RUN);
         sleep_go      <= (state == ST_RUN) && (nxt == ST_RUN) && sleep_req && !stby_en;
         prst_q        <= (state == ST_RUN) && (nxt == ST_SW_STBY);
      end
   end

   for (genvar g = 0; g < N_GRP; g++) begin : g_prst
      assign periph_rst[g] = prst_q;
   end

   assign osc_en = (state != ST_SW_STBY) && (state != ST_HW_STBY);
   assign clk_en = (state == ST_RUN) || ((state == ST_RST_HOLD) && tmr_settled);

endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk #(
   parameter int N_GRP = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             osc_en,
   input logic             clk_en,
   input logic [N_GRP-1:0] periph_rst,
   input logic             int_start,
   input logic             rst_exc_start,
   input logic             sleep_go,
   input logic             hw_s
);

   p_sleep_go_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_go |-> (clk_en && osc_en));

   p_sleep_go_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_go |=> !sleep_go);

   p_no_clk_wo_osc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> !clk_en);

   p_prst_in_stby_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|periph_rst) |-> !osc_en);

   p_prst_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|periph_rst) |=> (periph_rst == '0));

   p_clk_after_osc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en) |-> $past(osc_en));

   p_int_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int_start |=> !int_start);

   p_int_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int_start |-> (clk_en && !rst_exc_start));

   p_rexc_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_exc_start |-> clk_en);

   p_rexc_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_exc_start |=> !rst_exc_start);

   p_hw_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_s |=> (!osc_en && !clk_en));

endmodule

bind stby_ctrl stby_ctrl_chk #(.N_GRP(N_GRP)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .osc_en        (osc_en),
   .clk_en        (clk_en),
   .periph_rst    (periph_rst),
   .int_start     (int_start),
   .rst_exc_start (rst_exc_start),
   .sleep_go      (sleep_go),
   .hw_s          (hw_s)
);

// File: tb/stby_ctrl_bench.sv
`timescale 1ns/1ps
module stby_ctrl_bench;

   localparam int NI = 6;
   localparam int SW = 3;
   localparam int BB = 2;
   localparam int BS = 1;
   localparam int NG = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_req = 1'b0;
   logic          stby_en = 1'b0;
   logic [SW-1:0] settle_sel = '0;
   logic          nmi_n = 1'b1;
   logic [NI-1:0] irq_lvl = '0, irq_en = '0, irq_masked = '0, irq_to_dma = '0;
   logic          res_n = 1'b1;
   logic          hwstby_n = 1'b1;
   logic          osc_en, clk_en, int_start, rst_exc_start, sleep_go;
   logic [NG-1:0] periph_rst;

   always #10 clk = ~clk;

   stby_ctrl #(.NUM_IRQ(NI), .SEL_W(SW), .BASE_EXP(BB), .EXP_STEP(BS),
               .SYNC_STAGES(2), .N_GRP(NG), .NMI_EDGE(1'b1)) u_stby_ctrl (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_en(stby_en),
      .settle_sel(settle_sel), .nmi_n(nmi_n), .irq_lvl(irq_lvl), .irq_en(irq_en),
      .irq_masked(irq_masked), .irq_to_dma(irq_to_dma), .res_n(res_n),
      .hwstby_n(hwstby_n), .osc_en(osc_en), .clk_en(clk_en),
      .periph_rst(periph_rst), .int_start(int_start),
      .rst_exc_start(rst_exc_start), .sleep_go(sleep_go));

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int int_cnt  = 0;
   int rexc_cnt = 0;

   function automatic int settle_len(int k);
      return 1 << (BB + BS * k);
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
   endtask

   // ---------------- behavioural reference model ----------------
   // states: 0 run, 1 software standby, 2 settling, 3 hardware standby, 4 reset hold
   int m_st = 0, m_rem = 0;
   bit m_int = 0, m_rexc = 0, m_prst = 0, m_sgo = 0;
   bit nmi_q[2], res_q[2], hw_q[2], nprev;
   logic [NI-1:0] irq_q[2];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_rem = 0; m_int = 0; m_rexc = 0; m_prst = 0; m_sgo = 0;
         nmi_q = '{1, 1}; res_q = '{1, 1}; hw_q = '{1, 1}; nprev = 1;
         irq_q[0] = '0; irq_q[1] = '0;
      end else begin
         bit wake, start;
         int nst;
         wake  = (nprev && !nmi_q[1]) || ((irq_q[1] & irq_en & ~irq_masked & ~irq_to_dma) != 0);
         nst   = m_st;
         start = 0;
         if (!hw_q[1]) nst = 3;
         else if (m_st == 0) begin
            if (!res_q[1]) nst = 4;
            else if (sleep_req && stby_en) nst = 1;
         end else if (m_st == 1) begin
            if (!res_q[1]) begin nst = 4; start = 1; end
            else if (wake) begin nst = 2; start = 1; end
         end else if (m_st == 2) begin
            if (!res_q[1]) nst = 4;
            else if (m_rem == 1) nst = 0;
         end else if (m_st == 3) begin
            nst = 4; start = 1;
         end else begin
            if (res_q[1] && m_rem == 0) nst = 0;
         end
         m_int  = (m_st == 2 && nst == 0);
         m_rexc = (m_st == 4 && nst == 0);
         m_prst = (m_st == 0 && nst == 1);
         m_sgo  = (m_st == 0 && nst == 0 && sleep_req && !stby_en);
         if (start) m_rem = settle_len(int'(settle_sel));
         else if (m_rem > 0) m_rem--;
         nprev = nmi_q[1];
         nmi_q[1] = nmi_q[0]; nmi_q[0] = nmi_n;
         res_q[1] = res_q[0]; res_q[0] = res_n;
         hw_q[1]  = hw_q[0];  hw_q[0]  = hwstby_n;
         irq_q[1] = irq_q[0]; irq_q[0] = irq_lvl;
         m_st = nst;
      end
   end

   // per-cycle comparison against the model (R11 covers the synchroniser latency)
   always @(negedge clk) begin
      if (rst_n) begin
         bit e_osc, e_clk;
         e_osc = !(m_st == 1 || m_st == 3);
         e_clk = (m_st == 0) || (m_st == 4 && m_rem == 0);
         n_checks++;
         if (osc_en !== e_osc) begin
            n_fail++; $display("FAIL R2/R11 cyc=%0d osc_en actual=%0d expected=%0d", cyc, osc_en, e_osc);
         end
         if (clk_en !== e_clk) begin
            n_fail++; $display("FAIL R4/R7 cyc=%0d clk_en actual=%0d expected=%0d", cyc, clk_en, e_clk);
         end
         if (periph_rst !== {NG{m_prst}}) begin
            n_fail++; $display("FAIL R3 cyc=%0d periph_rst actual=%0d expected=%0d", cyc, periph_rst, {NG{m_prst}});
         end
         if (int_start !== m_int) begin
            n_fail++; $display("FAIL R4/R9 cyc=%0d int_start actual=%0d expected=%0d", cyc, int_start, m_int);
         end
         if (rst_exc_start !== m_rexc) begin
            n_fail++; $display("FAIL R6 cyc=%0d rst_exc_start actual=%0d expected=%0d", cyc, rst_exc_start, m_rexc);
         end
         if (sleep_go !== m_sgo) begin
            n_fail++; $display("FAIL R1 cyc=%0d sleep_go actual=%0d expected=%0d", cyc, sleep_go, m_sgo);
         end
         if (int_start === 1'b1) int_cnt++;
         if (rst_exc_start === 1'b1) rexc_cnt++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 150000);
         report();
         $finish;
      end
   end

   // ---------------- directed scenarios ----------------
   task automatic wait_n(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic go_standby(int k);
      stby_en    = 1'b1;
      settle_sel = SW'(k);
      sleep_req  = 1'b1;
      @(negedge clk);
      sleep_req  = 1'b0;
      @(negedge clk);
   endtask

   task automatic measure(int exp_len, string req);
      int n = 0;
      int guard = 0;
      while (!osc_en && guard < 50) begin @(negedge clk); guard++; end
      while (!clk_en && n < 2000) begin n++; @(negedge clk); end
      chk(req, "settling cycles", n, exp_len);
   endtask

   initial begin
      int i0, r0;
      wait_n(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "osc_en after reset", osc_en, 1);
      chk("R1", "clk_en after reset", clk_en, 1);

      // R1 ordinary sleep path
      stby_en = 1'b0; sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      chk("R1", "sleep_go pulse", sleep_go, 1);
      chk("R1", "clk_en stays on", clk_en, 1);
      @(negedge clk);
      chk("R1", "sleep_go single", sleep_go, 0);

      // R2, R3 entry
      stby_en = 1'b1; settle_sel = 3'd0; sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      chk("R3", "periph_rst on entry", int'(periph_rst), (1 << NG) - 1);
      chk("R2", "osc_en in standby", osc_en, 0);
      chk("R2", "clk_en in standby", clk_en, 0);
      @(negedge clk);
      chk("R3", "periph_rst one cycle", int'(periph_rst), 0);

      // R5 disqualified IRQ
      irq_lvl[0] = 1'b1;
      wait_n(8);
      chk("R5", "irq disabled no wake", osc_en, 0);
      irq_en[0] = 1'b1; irq_masked[0] = 1'b1;
      wait_n(8);
      chk("R5", "irq masked no wake", osc_en, 0);
      irq_masked[0] = 1'b0; irq_to_dma[0] = 1'b1;
      wait_n(8);
      chk("R5", "irq to transfer no wake", osc_en, 0);
      i0 = int_cnt;
      irq_to_dma[0] = 1'b0;
      measure(settle_len(0), "R4");
      irq_lvl = '0; irq_en = '0;
      wait_n(2);
      chk("R4", "int_start count", int_cnt - i0, 1);

      // R4 other selector values
      go_standby(3);
      irq_en[5] = 1'b1; irq_lvl[5] = 1'b1;
      measure(settle_len(3), "R4");
      irq_lvl = '0; irq_en = '0;
      wait_n(3);
      go_standby(7);
      irq_en[3] = 1'b1; irq_lvl[3] = 1'b1;
      measure(settle_len(7), "R4");
      irq_lvl = '0; irq_en = '0;
      wait_n(3);

      // R10 NMI edge only
      nmi_n = 1'b0;
      wait_n(5);
      chk("R10", "nmi in run no effect", clk_en, 1);
      go_standby(1);
      wait_n(10);
      chk("R10", "held-low nmi no wake", osc_en, 0);
      nmi_n = 1'b1;
      wait_n(4);
      chk("R10", "nmi rising no wake", osc_en, 0);
      nmi_n = 1'b0;
      measure(settle_len(1), "R10");
      nmi_n = 1'b1;
      wait_n(4);

      // R6 reset exit
      go_standby(2);
      i0 = int_cnt; r0 = rexc_cnt;
      res_n = 1'b0;
      wait_n(settle_len(2) + 6);
      chk("R6", "osc_en under reset", osc_en, 1);
      chk("R6", "clk_en after settling", clk_en, 1);
      res_n = 1'b1;
      wait_n(6);
      chk("R6", "rst_exc_start count", rexc_cnt - r0, 1);
      chk("R6", "no int_start", int_cnt - i0, 0);

      // R7 early release
      go_standby(5);
      r0 = rexc_cnt;
      res_n = 1'b0;
      wait_n(3);
      res_n = 1'b1;
      wait_n(20);
      chk("R7", "osc_en on", osc_en, 1);
      chk("R7", "clk_en held off", clk_en, 0);
      chk("R7", "no early rst_exc", rexc_cnt - r0, 0);
      wait_n(settle_len(5) + 5);
      chk("R7", "clk_en after count", clk_en, 1);
      chk("R7", "rst_exc after count", rexc_cnt - r0, 1);

      // R8, R9 hardware standby from run
      i0 = int_cnt; r0 = rexc_cnt;
      settle_sel = 3'd1;
      hwstby_n = 1'b0; res_n = 1'b0;
      wait_n(4);
      chk("R8", "osc_en in hw standby", osc_en, 0);
      chk("R8", "clk_en in hw standby", clk_en, 0);
      hwstby_n = 1'b1;
      wait_n(settle_len(1) + 6);
      res_n = 1'b1;
      wait_n(6);
      chk("R9", "clk_en after hw exit", clk_en, 1);
      chk("R9", "rst_exc after hw exit", rexc_cnt - r0, 1);
      chk("R9", "no int_start after hw exit", int_cnt - i0, 0);

      // R8 priority during settling, with wake held and reset low
      go_standby(7);
      i0 = int_cnt;
      irq_en[1] = 1'b1; irq_lvl[1] = 1'b1;
      wait_n(8);
      chk("R8", "settling osc on", osc_en, 1);
      hwstby_n = 1'b0; res_n = 1'b0;
      wait_n(4);
      chk("R8", "hw beats settling and reset", osc_en, 0);
      irq_lvl = '0; irq_en = '0;
      settle_sel = 3'd0;
      hwstby_n = 1'b1; res_n = 1'b1;
      wait_n(settle_len(0) + 10);
      chk("R9", "clk_en restored", clk_en, 1);
      chk("R9", "no int_start from hw path", int_cnt - i0, 0);

      report();
      $finish;
   end

endmodule